// File: doc/BRIEF.md
# Reference-Clock Period Meter

This block times an unknown, slower clock against a faster reference clock of known frequency. The unknown clock is not used as a clock inside the block. It is treated as an asynchronous data input. It passes through a synchronizer into the reference domain, and its rising edges are detected there. A counter running at the reference rate counts the reference cycles between successive rising edges. Each time a full period completes, the block publishes the count together with a one-cycle valid strobe. The measurement error is about one reference cycle. To resolve an input period into N parts, the reference must run at least N times faster than the fastest expected input.

Two fault conditions are reported. A period too long for the counter saturates the count and raises a sticky overflow flag. An input that stops toggling for a programmable number of reference cycles raises a no-clock flag. After that the block re-arms as it would after reset, so stale timing is never published. Converting the count to a frequency is left to the consumer.

Top module: `clk_period_meter`

## Requirements
- R1: While `rst_ni` is low, `period_o`, `valid_o`, `overflow_o` and `no_clock_o` are all 0.
- R2: Rising edges of `meas_clk_i` are seen after SYNC_STAGES+1 reference flops. At each seen edge (other than an arming edge) `period_o` is loaded with the number of reference cycles since the previous seen edge, and counting restarts at 1.
- R3: `valid_o` is high for exactly one reference cycle per completed period, in the same cycle that `period_o` takes its new value.
- R4: The first edge after reset, and the first edge after a no-clock timeout, only arm the counter. No valid strobe is produced for it, so the first strobe comes on the second edge.
- R5: The count saturates at 2^CNT_W-1. Once it reaches that value, `overflow_o` goes high and stays high, and a period at or above the maximum is published as 2^CNT_W-1 with `overflow_o` = 1.
- R6: `overflow_o` clears at the next published measurement whose count is below the maximum.
- R7: When TIMEOUT reference cycles pass with no seen edge, `no_clock_o` goes to 1. It returns to 0 at the next seen edge. No valid strobe occurs while it is 1.
- R8: An input whose high and low phases each last at least one reference cycle is measured. The shortest such period, 2 reference cycles, reads as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock of known frequency |
| rst_ni | input | 1 | Active-low asynchronous reset |
| meas_clk_i | input | 1 | Unknown clock, asynchronous to clk_i |
| period_o | output | CNT_W | Reference cycles in the last completed period |
| valid_o | output | 1 | One-cycle strobe marking a new `period_o` |
| overflow_o | output | 1 | Sticky flag: period reached the counter maximum |
| no_clock_o | output | 1 | No input edge within TIMEOUT reference cycles |

## Verification
The main measurement is driven with input clocks of varied period and duty cycle. These include the 2-cycle minimum, short and long odd periods, one period just below the counter maximum, one exactly at it, and one above it. A wrong off-by-one in the restart value, a lost edge, or a duty-cycle dependency each show up as a wrong count. Every period change also checks that the overflow flag both sets and clears on the right measurement. Separate runs stop the input until the timeout fires and apply reset mid-stream. These runs show that the arming edge after either event is never published.

// File: rtl/clk_meter_pkg.sv
package clk_meter_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } meter_state_e;
endpackage

// File: rtl/cm_edge_sync.sv
module cm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  // STAGES synchronizer flops plus one edge-history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  AST_RISE_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);  // R8
endmodule

// File: rtl/cm_period_counter.sv
module cm_period_counter
  import clk_meter_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             timeout_i,
  output logic [CNT_W-1:0] period_o,
  output logic             valid_o,
  output logic             overflow_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  meter_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      period_o   <= '0;
      valid_o    <= 1'b0;
      overflow_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise_i) begin
        state_q <= ST_ARMED;
        cnt_q   <= CNT_ONE;
        if (state_q == ST_ARMED) begin
          period_o   <= cnt_q;
          valid_o    <= 1'b1;
          overflow_o <= at_max;
        end
      end else if (timeout_i) begin
        // lost input: drop the partial period, re-arm on next edge
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (state_q == ST_ARMED) begin
        if (!at_max) cnt_q      <= cnt_q + 1'b1;
        else         overflow_o <= 1'b1;
      end
    end
  end

  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> cnt_q == CNT_ONE);  // R2
  AST_FIRST_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && state_q == ST_IDLE) |=> !valid_o);  // R4
  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_max && !rise_i && !timeout_i) |=> at_max);  // R5
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && at_max && !timeout_i) |=> overflow_o);  // R5
  AST_OVF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && period_o != CNT_MAX) |-> !overflow_o);  // R6
endmodule

// File: rtl/cm_idle_timer.sv
module cm_idle_timer #(
  parameter int unsigned TIMEOUT = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  output logic timeout_o,
  output logic no_clock_o
);
  localparam int unsigned   TO_W    = $clog2(TIMEOUT + 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT - 1);

  logic [TO_W-1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q     <= '0;
      no_clock_o <= 1'b0;
    end else if (rise_i) begin
      idle_q     <= '0;
      no_clock_o <= 1'b0;
    end else if (idle_q == TO_LAST) begin
      no_clock_o <= 1'b1;
    end else begin
      idle_q <= idle_q + 1'b1;
    end
  end

  // single-cycle pulse when the quiet window expires
  assign timeout_o = !rise_i && !no_clock_o && (idle_q == TO_LAST);

  AST_NOCLK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> !no_clock_o);  // R7
  AST_NOCLK_STICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_clock_o && !rise_i) |=> no_clock_o);  // R7
endmodule

// File: rtl/clk_period_meter.sv
module clk_period_meter #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned TIMEOUT     = 100000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             meas_clk_i,
  output logic [CNT_W-1:0] period_o,
  output logic             valid_o,
  output logic             overflow_o,
  output logic             no_clock_o
);
  logic rise;
  logic timeout;

  cm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (meas_clk_i),
    .rise_o  (rise)
  );

  cm_idle_timer #(.TIMEOUT(TIMEOUT)) u_idle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .timeout_o  (timeout),
    .no_clock_o (no_clock_o)
  );

  cm_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .timeout_i  (timeout),
    .period_o   (period_o),
    .valid_o    (valid_o),
    .overflow_o (overflow_o)
  );

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);  // R3
  AST_NO_VALID_NOCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_clock_o |-> !valid_o);  // R7
endmodule

// File: tb/clk_period_meter_test.sv
module clk_period_meter_test;
  localparam int unsigned CW  = 6;
  localparam int unsigned TO  = 100;
  localparam int unsigned MAXC = (1 << CW) - 1;
  localparam int unsigned NV  = 9;
  // {period, high cycles}
  localparam int unsigned VEC [NV][2] = '{
    '{8, 4}, '{9, 3}, '{2, 1}, '{3, 2}, '{20, 1},
    '{62, 31}, '{63, 10}, '{70, 35}, '{5, 2}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          meas = 1'b0;
  logic [CW-1:0] period;
  logic          valid, ovf, noclk;

  int unsigned n_chk = 0, n_fail = 0, vcount = 0, last_p = 0;

  always #5 clk = ~clk;

  clk_period_meter #(.CNT_W(CW), .TIMEOUT(TO), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .meas_clk_i(meas),
    .period_o(period), .valid_o(valid), .overflow_o(ovf), .no_clock_o(noclk));

  always @(negedge clk) begin
    if (rst_n && valid) begin
      vcount = vcount + 1;
      last_p = period;
    end
  end

  task automatic chk(input string req, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edge_p(input int unsigned p, input int unsigned hi);
    @(negedge clk) meas = 1'b1;
    repeat (hi) @(negedge clk);
    meas = 1'b0;
    repeat (p - hi - 1) @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned base;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 period", period, 0);
    chk("R1 valid", valid, 0);
    chk("R1 overflow", ovf, 0);
    chk("R1 no_clock", noclk, 0);
    rst_n = 1'b1;

    // R4: a lone first edge only arms
    base = vcount;
    edge_p(10, 5);
    settle();
    chk("R4 first edge", vcount - base, 0);
    edge_p(10, 5);
    settle();
    chk("R4 second edge", vcount - base, 1);
    chk("R2 first period", last_p, 14);

    // R2 R3 R5 R6 R8: table walk, three edges per entry
    for (int i = 0; i < NV; i++) begin
      base = vcount;
      repeat (3) edge_p(VEC[i][0], VEC[i][1]);
      settle();
      chk("R3 strobes", vcount - base, 3);
      chk((VEC[i][0] >= MAXC) ? "R5 period" : "R2 period", last_p,
          (VEC[i][0] >= MAXC) ? MAXC : VEC[i][0]);
      chk((VEC[i][0] >= MAXC) ? "R5 overflow" : "R6 overflow", ovf,
          (VEC[i][0] >= MAXC) ? 1 : 0);
    end

    // R7: stop the input
    base = vcount;
    repeat (TO + 10) @(negedge clk);
    #1;
    chk("R7 no_clock set", noclk, 1);
    chk("R7 no strobe", vcount - base, 0);
    repeat (3) edge_p(12, 6);
    settle();
    chk("R7 no_clock clear", noclk, 0);
    chk("R4 re-arm", vcount - base, 2);
    chk("R2 after timeout", last_p, 12);

    // R1: reset mid-stream, then R4 again
    repeat (2) edge_p(10, 5);
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 mid period", period, 0);
    chk("R1 mid overflow", ovf, 0);
    chk("R1 mid no_clock", noclk, 0);
    rst_n = 1'b1;
    base = vcount;
    edge_p(10, 5);
    settle();
    chk("R4 after reset", vcount - base, 0);
    edge_p(10, 5);
    settle();
    chk("R4 after reset second", vcount - base, 1);
    chk("R2 after reset", last_p, 14);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule